// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

This block is a serial shift register with a parameterised number of stages (32 by default). On each rising clock edge its contents move one stage toward the high end or toward the low end. The bit that enters the vacated end stage comes either from that end's serial input or from the stage at the opposite end, which is recirculation. A hold input stops all movement. Stage 1 sits at the low end and stage N at the high end.

Each end stage drives a serial output through a flop clocked on the falling edge. A value shifted into an end stage therefore appears on its output half a cycle after the rising edge, and it stays stable through the next rising edge. Instances can be chained by wiring the serial outputs of one instance to the serial inputs of the next. Shifting toward the high end and then back toward the low end makes the register a bit stack, with the last bit in being the first bit out.

Top module: `bidir_recirc_shreg`

## Requirements
- R1: An active-low asynchronous reset clears every stage to 0 and drives both serial outputs to 0.
- R2: On a rising edge with `dir_left`=0, `ext_sel`=1 and `hold`=0, stage 1 takes `ser_in_r` and every stage k (k>1) takes the old value of stage k-1.
- R3: On a rising edge with `dir_left`=1, `ext_sel`=1 and `hold`=0, stage N takes `ser_in_l` and every stage k (k<N) takes the old value of stage k+1.
- R4: With `dir_left`=0, `ext_sel`=0 and `hold`=0, stage 1 takes the old value of stage N. N such edges in a row restore the original contents.
- R5: With `dir_left`=1, `ext_sel`=0 and `hold`=0, stage N takes the old value of stage 1. N such edges in a row restore the original contents.
- R6: While `hold`=1, a rising edge changes no stage and neither output, whatever the other inputs are.
- R7: `ser_out_l` shows stage 1 and `ser_out_r` shows stage N. Each updates at the falling edge after a shift and still holds its old value just after the rising edge.
- R8: After bits are pushed with shifts toward stage N using `ser_in_r`, reading `ser_out_l` before each shift toward stage 1 returns those bits in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages shift on the rising edge, outputs capture on the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_left | input | 1 | 0 = move toward stage N, 1 = move toward stage 1 |
| ext_sel | input | 1 | 1 = end stage fed from serial input, 0 = recirculate far end |
| hold | input | 1 | 1 = no shift on this rising edge |
| ser_in_r | input | 1 | Serial input entering stage 1 |
| ser_in_l | input | 1 | Serial input entering stage N |
| ser_out_l | output | 1 | Stage 1 value, captured on the falling edge |
| ser_out_r | output | 1 | Stage N value, captured on the falling edge |

## Verification
During recirculation, two things happen on the same edge. The bit leaving one end stage wraps into the other end stage. The outputs then capture both end stages on the following falling edge, so a bit can leave stage N and reappear on `ser_out_l` within a single cycle. Long recirculation runs in both directions provoke this overlap, and holds are interleaved with changing inputs between them. Both outputs are compared in every low phase against a bench model built from the requirements. After full N-cycle rotations, the contents are dumped serially and compared with the word that was loaded.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic {
    DIR_RIGHT = 1'b0,
    DIR_LEFT  = 1'b1
  } shift_dir_t;

  typedef struct packed {
    logic dir_left;
    logic ext_sel;
    logic hold;
  } shreg_ctl_t;

  // Bit entering an end stage: the serial input, or the far end when wrapping.
  function automatic logic pick_feed(input logic ext_sel, input logic ext_bit,
                                     input logic wrap_bit);
    return ext_sel ? ext_bit : wrap_bit;
  endfunction

  // Next value of one stage, given its neighbours toward stage 1 (lo) and toward stage N (hi).
  function automatic logic stage_next(input logic shift_en, input logic move_left,
                                      input logic lo, input logic hi, input logic cur);
    logic nxt;
    if (!shift_en)     nxt = cur;
    else if (move_left) nxt = hi;
    else               nxt = lo;
    return nxt;
  endfunction

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
(
  input  shreg_ctl_t ctl,
  input  logic       ser_in_r,
  input  logic       ser_in_l,
  input  logic       first_bit,
  input  logic       last_bit,
  output logic       shift_en,
  output logic       move_left,
  output logic       feed_right,
  output logic       feed_left
);

  shift_dir_t dir;

  assign dir        = shift_dir_t'(ctl.dir_left);
  assign shift_en   = !ctl.hold;
  assign move_left  = (dir == DIR_LEFT);
  assign feed_right = pick_feed(ctl.ext_sel, ser_in_r, last_bit);
  assign feed_left  = pick_feed(ctl.ext_sel, ser_in_l, first_bit);

endmodule

// File: rtl/shreg_stage_array.sv
module shreg_stage_array
  import shreg_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         move_left,
  input  logic         feed_right,
  input  logic         feed_left,
  output logic [N-1:0] stages
);

  localparam int LAST = N - 1;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic from_lo;
    logic from_hi;

    if (i == 0) begin : g_lo_end
      assign from_lo = feed_right;
    end else begin : g_lo_mid
      assign from_lo = stages[i-1];
    end

    if (i == LAST) begin : g_hi_end
      assign from_hi = feed_left;
    end else begin : g_hi_mid
      assign from_hi = stages[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages[i] <= 1'b0;
      else        stages[i] <= stage_next(shift_en, move_left, from_lo, from_hi, stages[i]);
    end
  end

endmodule

// File: rtl/shreg_end_capture.sv
module shreg_end_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic first_bit,
  input  logic last_bit,
  output logic out_first,
  output logic out_last
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_first <= first_bit;
      out_last  <= last_bit;
    end
  end

endmodule

// File: rtl/bidir_recirc_shreg.sv
module bidir_recirc_shreg
  import shreg_pkg::*;
#(
  parameter int STAGES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_left,
  input  logic ext_sel,
  input  logic hold,
  input  logic ser_in_r,
  input  logic ser_in_l,
  output logic ser_out_l,
  output logic ser_out_r
);

  localparam int LAST = STAGES - 1;

  shreg_ctl_t        ctl;
  logic              shift_en;
  logic              move_left;
  logic              feed_right;
  logic              feed_left;
  logic [STAGES-1:0] stages;
  logic              first_bit;
  logic              last_bit;

  assign ctl       = '{dir_left: dir_left, ext_sel: ext_sel, hold: hold};
  assign first_bit = stages[0];
  assign last_bit  = stages[LAST];

  shreg_ctrl u_ctrl (
    .ctl        (ctl),
    .ser_in_r   (ser_in_r),
    .ser_in_l   (ser_in_l),
    .first_bit  (first_bit),
    .last_bit   (last_bit),
    .shift_en   (shift_en),
    .move_left  (move_left),
    .feed_right (feed_right),
    .feed_left  (feed_left)
  );

  shreg_stage_array #(.N(STAGES)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .move_left  (move_left),
    .feed_right (feed_right),
    .feed_left  (feed_left),
    .stages     (stages)
  );

  shreg_end_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_bit (first_bit),
    .last_bit  (last_bit),
    .out_first (ser_out_l),
    .out_last  (ser_out_r)
  );

endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dir_left,
  input logic         ext_sel,
  input logic         hold,
  input logic         ser_in_r,
  input logic         ser_in_l,
  input logic [N-1:0] stages,
  input logic         ser_out_l,
  input logic         ser_out_r
);

  a_r2_right_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !dir_left && ext_sel) |=> stages[0] == $past(ser_in_r));

  a_r2_right_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !dir_left) |=> stages[N-1:1] == $past(stages[N-2:0]));

  a_r3_left_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && dir_left && ext_sel) |=> stages[N-1] == $past(ser_in_l));

  a_r3_left_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && dir_left) |=> stages[N-2:0] == $past(stages[N-1:1]));

  a_r4_right_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !dir_left && !ext_sel) |=> stages[0] == $past(stages[N-1]));

  a_r5_left_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && dir_left && !ext_sel) |=> stages[N-1] == $past(stages[0]));

  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(stages));

  a_r7_outputs_track: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out_l == stages[0]) && (ser_out_r == stages[N-1]));

endmodule

bind bidir_recirc_shreg shreg_checker #(.N(STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_left  (dir_left),
  .ext_sel   (ext_sel),
  .hold      (hold),
  .ser_in_r  (ser_in_r),
  .ser_in_l  (ser_in_l),
  .stages    (stages),
  .ser_out_l (ser_out_l),
  .ser_out_r (ser_out_r)
);

// File: tb/test_bidir_recirc_shreg.sv
`timescale 1ns/1ps
module test_bidir_recirc_shreg;

  localparam int NST = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_left = 1'b0, ext_sel = 1'b1, hold = 1'b0, ser_in_r = 1'b0, ser_in_l = 1'b0;
  logic ser_out_l, ser_out_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NST-1:0] model = '0;

  bidir_recirc_shreg #(.STAGES(NST)) i_bidir_recirc_shreg (
    .clk(clk), .rst_n(rst_n), .dir_left(dir_left), .ext_sel(ext_sel), .hold(hold),
    .ser_in_r(ser_in_r), .ser_in_l(ser_in_l), .ser_out_l(ser_out_l), .ser_out_r(ser_out_r)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic        dl;
    logic        ex;
    logic        hd;
    logic [31:0] pr;
    logic [31:0] pl;
    logic [7:0]  n;
    logic [3:0]  tag;
  } seg_t;

  localparam seg_t SEGS [0:7] = '{
    '{1'b0, 1'b1, 1'b0, 32'hA5C3_0F1E, 32'h0000_0000, 8'd32, 4'd2},
    '{1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd20, 4'd4},
    '{1'b1, 1'b1, 1'b1, 32'h5555_5555, 32'hAAAA_AAAA, 8'd5,  4'd6},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'h1234_F0E1, 8'd12, 4'd3},
    '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 8'd40, 4'd5},
    '{1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd4,  4'd6},
    '{1'b0, 1'b0, 1'b1, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 8'd3,  4'd6},
    '{1'b0, 1'b1, 1'b0, 32'h0000_00D6, 32'h0000_0000, 8'd8,  4'd2}
  };

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic d, input logic e, input logic h,
                       input logic ir, input logic il);
    dir_left = d; ext_sel = e; hold = h; ser_in_r = ir; ser_in_l = il;
  endtask

  // One full cycle; returns in the low phase after the outputs have been captured.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic model_update();
    logic fb;
    if (!hold) begin
      if (!dir_left) begin
        fb = ext_sel ? ser_in_r : model[NST-1];
        model = {model[NST-2:0], fb};
      end else begin
        fb = ext_sel ? ser_in_l : model[0];
        model = {fb, model[NST-1:1]};
      end
    end
  endtask

  task automatic load_right(input logic [31:0] w);
    for (int j = 0; j < NST; j++) begin
      drive(1'b0, 1'b1, 1'b0, w[j], 1'b0);
      step();
    end
  endtask

  task automatic dump_right(output logic [31:0] got);
    for (int i = 0; i < NST; i++) begin
      got[i] = ser_out_r;
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] w;
    logic [4:0]  stack;

    // R1: reset state
    #12;
    chk("R1", "ser_out_l in reset", ser_out_l, 1'b0);
    chk("R1", "ser_out_r in reset", ser_out_r, 1'b0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    step();
    chk("R1", "ser_out_l after reset", ser_out_l, 1'b0);
    chk("R1", "ser_out_r after reset", ser_out_r, 1'b0);
    model = '0;

    // Table walk: every cycle both outputs are compared against the model.
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < int'(SEGS[s].n); c++) begin
        drive(SEGS[s].dl, SEGS[s].ex, SEGS[s].hd, SEGS[s].pr[c % 32], SEGS[s].pl[c % 32]);
        step();
        model_update();
        chk(tname(SEGS[s].tag), "ser_out_l", ser_out_l, model[0]);
        chk(tname(SEGS[s].tag), "ser_out_r", ser_out_r, model[NST-1]);
      end
    end

    // R4: a full rightward rotation restores the loaded word
    w = 32'hC0DE_5A39;
    load_right(w);
    for (int k = 0; k < NST; k++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      step();
    end
    dump_right(got);
    checks++;
    if (got !== w) begin
      errors++;
      $display("FAIL R4 rotate right: actual=%h expected=%h", got, w);
    end

    // R5: a full leftward rotation restores the loaded word
    w = 32'h9E37_0B61;
    load_right(w);
    for (int k = 0; k < NST; k++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      step();
    end
    dump_right(got);
    checks++;
    if (got !== w) begin
      errors++;
      $display("FAIL R5 rotate left: actual=%h expected=%h", got, w);
    end

    // R6: hold with changing inputs, then dump to confirm contents unchanged
    w = 32'h7F01_A2C4;
    load_right(w);
    for (int k = 0; k < 6; k++) begin
      drive(k[0], k[1], 1'b1, ~k[0], k[2]);
      step();
      chk("R6", "ser_out_r held", ser_out_r, w[0]);
      chk("R6", "ser_out_l held", ser_out_l, w[31]);
    end
    dump_right(got);
    checks++;
    if (got !== w) begin
      errors++;
      $display("FAIL R6 contents after hold: actual=%h expected=%h", got, w);
    end

    // R8: push five bits, pop them in reverse order through ser_out_l
    stack = 5'b10110;
    for (int j = 0; j < 5; j++) begin
      drive(1'b0, 1'b1, 1'b0, stack[j], 1'b0);
      step();
    end
    for (int j = 4; j >= 0; j--) begin
      chk("R8", "pop order", ser_out_l, stack[j]);
      drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
    end

    // R1: reset in mid-run clears everything
    load_right(32'hFFFF_FFFF);
    rst_n = 1'b0;
    #2;
    chk("R1", "ser_out_l async clear", ser_out_l, 1'b0);
    chk("R1", "ser_out_r async clear", ser_out_r, 1'b0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    dump_right(got);
    checks++;
    if (got !== 32'h0) begin
      errors++;
      $display("FAIL R1 contents after reset: actual=%h expected=%h", got, 32'h0);
    end

    // R7: outputs change at the falling edge, not at the rising edge
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R7", "ser_out_l before falling edge", ser_out_l, 1'b0);
    @(negedge clk); #1;
    chk("R7", "ser_out_l after falling edge", ser_out_l, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    chk("R7", "ser_out_r before falling edge", ser_out_r, 1'b0);
    @(negedge clk); #1;
    chk("R7", "ser_out_r after falling edge", ser_out_r, 1'b1);

    done = 1'b1;
    finish_up();
  end

endmodule